// File: doc/BRIEF.md
# SDRAM Protocol Rule Checker

A passive monitor for a single-rank SDRAM command bus. On every rising clock edge it decodes the command from the clock-enable, chip-select and strobe pins. It keeps a small state record for each bank: closed, open, or closing under auto precharge. It compares each command against the bank-state prerequisites and the minimum cycle spacings, and it never drives the memory bus.

Timing limits are given as nanosecond parameters together with the clock period in picoseconds. Each limit becomes a cycle count, rounded up. When a command breaks a rule, the checker gives a one-cycle pulse and reports a violation code. The first code is held in a sticky register until a clear input is pulsed. Data values, self refresh, power-down and multiple ranks are not modelled.

Top module: `sdrc_checker`

## Requirements
- R1: After reset, err_pulse, err_sticky and err_code are 0. A cycle with cke low, with cs_n high, or with the strobes {ras_n,cas_n,we_n}=3'b111 is a no-operation and is never flagged. The other strobe codes, with cs_n low, are: 000 mode set, 001 refresh, 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop.
- R2: A mode set while any bank is not closed gives code 2. A refresh while any bank is not closed gives code 3.
- R3: Any command other than a no-operation in the first T_MRD-1 cycles after a mode set gives code 1. With the default T_MRD=2, a command two cycles after the mode set is legal.
- R4: A read or write to a bank that is not open gives code 5. A read or write fewer than tRCD cycles after that bank's activate gives code 6. At exactly tRCD cycles it is legal.
- R5: A precharge that closes an open bank fewer than tRAS cycles after its activate gives code 7.
- R6: An activate gives code 8 if its bank is not closed. It gives code 9 if fewer than tRP cycles have passed since that bank began precharging. It gives code 10 if fewer than tRC cycles have passed since that bank's previous activate. It gives code 11 if fewer than tRRD cycles have passed since any activate.
- R7: A precharge with addr_ap high closes every bank and ignores ba. With addr_ap low it closes only the bank given by ba.
- R8: A read or write with addr_ap high, issued in cycle t to an open bank, starts an auto-precharge burst of length BL. BL is latched from addr_bl at the last mode set: 0→1, 1→2, 2→4, 3→8, 7→full page of 2^COL_W. Any read or write in cycles t+1..t+BL-1 gives code 4. A read or write to another bank in cycle t+BL is legal. The bank counts as precharging from cycle t+BL, so an activate to it is legal from cycle t+BL+tRP.
- R9: Reads and writes on consecutive cycles are legal, and a burst stop is never flagged except under R3.
- R10: Every violating command gives err_pulse for one cycle, in the cycle after the command edge. When several rules fail at once, the lowest code is reported. The first code is held in err_code, with err_sticky high, until clr. A cycle with clr high loads the code of that same cycle, or 0 if there is none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears the held violation (loads the current cycle's code) |
| cke | input | 1 | Clock enable of the memory; low means the cycle is ignored |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank address |
| addr_ap | input | 1 | Address bit that selects auto precharge on reads/writes and all banks on precharge |
| addr_bl | input | 3 | Low address bits carrying the burst-length key at a mode set |
| err_pulse | output | 1 | One-cycle flag for a violation in the previous command cycle |
| err_sticky | output | 1 | High while a violation is held |
| err_code | output | 4 | Code of the held violation (0 = none) |

## Verification
The hardest state to reach from the ports is a bank closing under auto precharge. Reaching it takes a mode set that fixes the burst length, then an activate, then a column command with addr_ap high, all with legal spacing. Only then can the lock window, its exact last cycle and the precharge delay that follows be probed. The stimulus runs this sequence twice, once with an 8-beat burst and once with a 2-beat burst. It places reads and writes on the first and last locked cycles and on the first free cycle, and it places an activate one cycle before the precharge delay has run out. Cases where several rules fail in the same cycle are built on purpose, so that the lowest-code priority is observed.

// File: rtl/sdrc_pkg.sv
`timescale 1ns/1ps
package sdrc_pkg;

    typedef enum logic [2:0] {
        C_NOP, C_MODE, C_REF, C_ACT, C_RD, C_WR, C_PRE, C_BST
    } cmd_e;

    typedef enum logic [1:0] {
        B_CLOSED, B_OPEN, B_AUTOPRE
    } bank_e;

    // lower value wins when several rules fail in one cycle
    typedef enum logic [3:0] {
        V_NONE      = 4'd0,
        V_MRD       = 4'd1,
        V_MODE_BUSY = 4'd2,
        V_REF_BUSY  = 4'd3,
        V_AP_LOCK   = 4'd4,
        V_RW_CLOSED = 4'd5,
        V_RCD       = 4'd6,
        V_RAS       = 4'd7,
        V_ACT_OPEN  = 4'd8,
        V_RP        = 4'd9,
        V_RC        = 4'd10,
        V_RRD       = 4'd11
    } viol_e;

    localparam int NVIOL = 12;

    typedef struct packed {
        cmd_e kind;
        logic ap;      // auto precharge / all banks flag
    } cmd_t;

    function automatic int ns2cyc(input int ns, input int tck_ps);
        return (ns * 1000 + tck_ps - 1) / tck_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdrc_decode.sv
`timescale 1ns/1ps
module sdrc_decode
    import sdrc_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic addr_ap,
    output cmd_t cmd
);
    always_comb begin
        cmd.ap = addr_ap;
        if (!cke || cs_n) begin
            cmd.kind = C_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd.kind = C_MODE;
                3'b001:  cmd.kind = C_REF;
                3'b011:  cmd.kind = C_ACT;
                3'b101:  cmd.kind = C_RD;
                3'b100:  cmd.kind = C_WR;
                3'b010:  cmd.kind = C_PRE;
                3'b110:  cmd.kind = C_BST;
                default: cmd.kind = C_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdrc_bank.sv
`timescale 1ns/1ps
module sdrc_bank
    import sdrc_pkg::*;
#(
    parameter int CW    = 4,
    parameter int SAT   = 13,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd,
    input  logic             sel,
    input  logic [COL_W-1:0] bl_m1,
    output bank_e            st,
    output logic [CW-1:0]    act_age,
    output logic [CW-1:0]    pre_age,
    output logic             ap_busy
);
    localparam logic [CW-1:0] AGE_MAX = CW'(SAT);
    localparam logic [CW-1:0] AGE_ONE = CW'(1);

    logic [COL_W-1:0] ap_left;

    assign ap_busy = (st == B_AUTOPRE) && (ap_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= B_CLOSED;
            act_age <= AGE_MAX;
            pre_age <= AGE_MAX;
            ap_left <= '0;
        end else begin
            act_age <= (act_age == AGE_MAX) ? AGE_MAX : act_age + AGE_ONE;
            pre_age <= (pre_age == AGE_MAX) ? AGE_MAX : pre_age + AGE_ONE;
            if (st == B_AUTOPRE) begin
                if (ap_left == '0) begin
                    st      <= B_CLOSED;
                    pre_age <= AGE_ONE;
                end else begin
                    ap_left <= ap_left - 1'b1;
                end
            end
            if (sel && cmd.kind == C_ACT) begin
                st      <= B_OPEN;
                act_age <= AGE_ONE;
            end
            if (cmd.kind == C_PRE && (sel || cmd.ap) && st == B_OPEN) begin
                st      <= B_CLOSED;
                pre_age <= AGE_ONE;
            end
            if (sel && cmd.ap && st == B_OPEN &&
                (cmd.kind == C_RD || cmd.kind == C_WR)) begin
                st      <= B_AUTOPRE;
                ap_left <= bl_m1;
            end
        end
    end
endmodule

// File: rtl/sdrc_errhold.sv
`timescale 1ns/1ps
module sdrc_errhold
    import sdrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  viol_e      code_in,
    output logic       err_pulse,
    output logic       err_sticky,
    output logic [3:0] err_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_pulse  <= 1'b0;
            err_sticky <= 1'b0;
            err_code   <= 4'd0;
        end else begin
            err_pulse <= (code_in != V_NONE);
            if (clr) begin
                err_sticky <= (code_in != V_NONE);
                err_code   <= code_in;
            end else if (!err_sticky && code_in != V_NONE) begin
                err_sticky <= 1'b1;
                err_code   <= code_in;
            end
        end
    end
endmodule

// File: rtl/sdrc_checker.sv
`timescale 1ns/1ps
module sdrc_checker
    import sdrc_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int COL_W     = 8,
    parameter int TCK_PS    = 5000,
    parameter int T_RCD_NS  = 20,
    parameter int T_RAS_NS  = 45,
    parameter int T_RC_NS   = 65,
    parameter int T_RRD_NS  = 15,
    parameter int T_RP_NS   = 20,
    parameter int T_MRD     = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            addr_ap,
    input  logic [2:0]      addr_bl,
    output logic            err_pulse,
    output logic            err_sticky,
    output logic [3:0]      err_code
);
    localparam int NBANK = 1 << BA_W;
    localparam int RCD_I = ns2cyc(T_RCD_NS, TCK_PS);
    localparam int RAS_I = ns2cyc(T_RAS_NS, TCK_PS);
    localparam int RC_I  = ns2cyc(T_RC_NS, TCK_PS);
    localparam int RRD_I = ns2cyc(T_RRD_NS, TCK_PS);
    localparam int RP_I  = ns2cyc(T_RP_NS, TCK_PS);
    localparam int SAT   = imax(imax(imax(RCD_I, RAS_I), imax(RC_I, RRD_I)), RP_I);
    localparam int CW    = $clog2(SAT + 1);
    localparam int MW    = $clog2(T_MRD + 1);

    localparam logic [CW-1:0] RCD_C = CW'(RCD_I);
    localparam logic [CW-1:0] RAS_C = CW'(RAS_I);
    localparam logic [CW-1:0] RC_C  = CW'(RC_I);
    localparam logic [CW-1:0] RRD_C = CW'(RRD_I);
    localparam logic [CW-1:0] RP_C  = CW'(RP_I);
    localparam logic [CW-1:0] SAT_C = CW'(SAT);

    cmd_t             cmd;
    bank_e            st_arr  [NBANK];
    logic [CW-1:0]    act_arr [NBANK];
    logic [CW-1:0]    pre_arr [NBANK];
    logic [NBANK-1:0] busy_vec;
    logic [NBANK-1:0] used_vec;
    logic [NBANK-1:0] ras_vec;

    logic [COL_W-1:0] bl_m1, bl_key;
    logic [CW-1:0]    rrd_age;
    logic [MW-1:0]    mrd_left;
    logic [NVIOL-1:1] hit;
    viol_e            first;

    sdrc_decode u_dec (
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr_ap(addr_ap), .cmd(cmd)
    );

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        sdrc_bank #(.CW(CW), .SAT(SAT), .COL_W(COL_W)) u_bank (
            .clk(clk), .rst(rst), .cmd(cmd),
            .sel(ba == BA_W'(i)), .bl_m1(bl_m1),
            .st(st_arr[i]), .act_age(act_arr[i]),
            .pre_age(pre_arr[i]), .ap_busy(busy_vec[i])
        );
        assign used_vec[i] = (st_arr[i] != B_CLOSED);
        assign ras_vec[i]  = (st_arr[i] == B_OPEN) && (act_arr[i] < RAS_C);
    end

    // burst-length key from the mode word
    always_comb begin
        unique case (addr_bl)
            3'd0:    bl_key = '0;
            3'd1:    bl_key = COL_W'(1);
            3'd2:    bl_key = COL_W'(3);
            3'd3:    bl_key = COL_W'(7);
            3'd7:    bl_key = '1;
            default: bl_key = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bl_m1    <= '0;
            rrd_age  <= SAT_C;
            mrd_left <= '0;
        end else begin
            rrd_age  <= (rrd_age == SAT_C) ? SAT_C : rrd_age + 1'b1;
            if (mrd_left != '0) mrd_left <= mrd_left - 1'b1;
            if (cmd.kind == C_ACT) rrd_age <= CW'(1);
            if (cmd.kind == C_MODE) begin
                bl_m1    <= bl_key;
                mrd_left <= MW'(T_MRD - 1);
            end
        end
    end

    always_comb begin
        hit = '0;
        if (mrd_left != '0 && cmd.kind != C_NOP) hit[int'(V_MRD)] = 1'b1;
        unique case (cmd.kind)
            C_MODE: if (|used_vec) hit[int'(V_MODE_BUSY)] = 1'b1;
            C_REF:  if (|used_vec) hit[int'(V_REF_BUSY)]  = 1'b1;
            C_RD, C_WR: begin
                if (|busy_vec) hit[int'(V_AP_LOCK)] = 1'b1;
                if (st_arr[ba] != B_OPEN)  hit[int'(V_RW_CLOSED)] = 1'b1;
                else if (act_arr[ba] < RCD_C) hit[int'(V_RCD)] = 1'b1;
            end
            C_PRE: begin
                if (cmd.ap ? (|ras_vec) : ras_vec[ba]) hit[int'(V_RAS)] = 1'b1;
            end
            C_ACT: begin
                if (st_arr[ba] != B_CLOSED) hit[int'(V_ACT_OPEN)] = 1'b1;
                if (pre_arr[ba] < RP_C)     hit[int'(V_RP)]       = 1'b1;
                if (act_arr[ba] < RC_C)     hit[int'(V_RC)]       = 1'b1;
                if (rrd_age < RRD_C)        hit[int'(V_RRD)]      = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        first = V_NONE;
        for (int k = NVIOL - 1; k >= 1; k--) begin
            if (hit[k]) first = viol_e'(k);
        end
    end

    sdrc_errhold u_err (
        .clk(clk), .rst(rst), .clr(clr), .code_in(first),
        .err_pulse(err_pulse), .err_sticky(err_sticky), .err_code(err_code)
    );
endmodule

// File: rtl/sdrc_checker_sva.sv
`timescale 1ns/1ps
module sdrc_checker_sva #(
    parameter int BA_W  = 2,
    parameter int T_MRD = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            clr,
    input logic            cke,
    input logic            cs_n,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic [BA_W-1:0] ba,
    input logic            addr_ap,
    input logic [2:0]      addr_bl,
    input logic            err_pulse,
    input logic            err_sticky,
    input logic [3:0]      err_code
);
    logic live, mode_now, idle_now;
    assign live     = cke && !cs_n && !(ras_n && cas_n && we_n);
    assign mode_now = cke && !cs_n && !ras_n && !cas_n && !we_n;
    assign idle_now = !cke || cs_n || (ras_n && cas_n && we_n);

    // R10: a pulse always leaves a held violation behind
    p_pulse_held_r10: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_sticky);

    // R10: a held violation carries a nonzero code
    p_code_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
        err_sticky |-> (err_code != 4'd0));

    // R10: without clr the held code never changes
    p_code_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (err_sticky && !clr) |=> (err_sticky && $stable(err_code)));

    // R3: a live command right after a mode set is flagged
    p_mode_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_now && T_MRD >= 2) ##1 live |=> err_pulse);

    // R1: idle pins never produce a pulse
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        idle_now |=> !err_pulse);

    logic unused_ok;
    assign unused_ok = ^{ba, addr_ap, addr_bl};
endmodule

bind sdrc_checker sdrc_checker_sva #(.BA_W(BA_W), .T_MRD(T_MRD)) u_sva (
    .clk(clk), .rst(rst), .clr(clr), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
    .addr_ap(addr_ap), .addr_bl(addr_bl), .err_pulse(err_pulse),
    .err_sticky(err_sticky), .err_code(err_code)
);

// File: tb/sdrc_checker_test.sv
`timescale 1ns/1ps
module sdrc_checker_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b1;
    logic cke = 1'b1;
    logic cs_n = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic addr_ap = 1'b0;
    logic [2:0] addr_bl = 3'd0;
    logic err_pulse, err_sticky;
    logic [3:0] err_code;

    always #2.5 clk = ~clk;

    sdrc_checker uut (
        .clk(clk), .rst(rst), .clr(clr), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
        .addr_ap(addr_ap), .addr_bl(addr_bl), .err_pulse(err_pulse),
        .err_sticky(err_sticky), .err_code(err_code)
    );

    localparam logic [2:0] K_MODE = 3'b000, K_REF = 3'b001, K_ACT = 3'b011,
                           K_RD = 3'b101, K_WR = 3'b100, K_PRE = 3'b010,
                           K_BST = 3'b110, K_NOP = 3'b111;

    typedef struct {
        logic       pulse;
        logic [3:0] code;
        string      tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // monitor: one expected item per command cycle
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            total++;
            if (err_pulse !== e.pulse || err_code !== e.code ||
                err_sticky !== (e.code != 4'd0)) begin
                bad++;
                $display("FAIL %s: pulse=%0b code=%0d sticky=%0b expected pulse=%0b code=%0d sticky=%0b",
                         e.tag, err_pulse, err_code, err_sticky,
                         e.pulse, e.code, (e.code != 4'd0));
            end
        end
    end

    task automatic issue(input logic [2:0] k, input logic csn, input logic ck,
                         input int bank, input logic ap, input logic [2:0] bl,
                         input logic c, input logic ep, input logic [3:0] ec,
                         input string tag);
        exp_t e;
        @(negedge clk);
        {ras_n, cas_n, we_n} = k;
        cs_n = csn; cke = ck; ba = 2'(bank); addr_ap = ap; addr_bl = bl; clr = c;
        @(posedge clk);
        #1;
        e.pulse = ep; e.code = ec; e.tag = tag;
        q.push_back(e);
    endtask

    // ordinary command with clr set, so err_code shows this cycle's code
    task automatic cmd(input logic [2:0] k, input int bank, input logic ap,
                       input logic [2:0] bl, input logic [3:0] ec, input string tag);
        issue(k, 1'b0, 1'b1, bank, ap, bl, 1'b1, ec != 4'd0, ec, tag);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) cmd(K_NOP, 0, 1'b0, 3'd0, 4'd0, "R1 idle");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        total++;
        if (err_pulse !== 1'b0 || err_sticky !== 1'b0 || err_code !== 4'd0) begin
            bad++;
            $display("FAIL R1 reset: pulse=%0b sticky=%0b code=%0d expected 0 0 0",
                     err_pulse, err_sticky, err_code);
        end
        // R3 mode quiet time
        cmd(K_MODE, 0, 0, 3'd3, 4'd0, "R3 mode set");
        cmd(K_REF,  0, 0, 3'd0, 4'd1, "R3 refresh one cycle after mode");
        cmd(K_MODE, 0, 0, 3'd3, 4'd0, "R3 mode set");
        nop(1);
        cmd(K_REF,  0, 0, 3'd0, 4'd0, "R3 refresh two cycles after mode");
        // R4 / R9 column rules
        cmd(K_RD,   0, 0, 3'd0, 4'd5, "R4 read closed bank");
        cmd(K_ACT,  0, 0, 3'd0, 4'd0, "R4 activate b0");
        cmd(K_RD,   0, 0, 3'd0, 4'd6, "R4 read at age 1");
        nop(1);
        cmd(K_RD,   0, 0, 3'd0, 4'd6, "R4 read at age 3");
        cmd(K_RD,   0, 0, 3'd0, 4'd0, "R4 read at tRCD");
        cmd(K_RD,   0, 0, 3'd0, 4'd0, "R9 back-to-back read");
        cmd(K_BST,  0, 0, 3'd0, 4'd0, "R9 burst stop");
        cmd(K_WR,   0, 0, 3'd0, 4'd0, "R9 write after stop");
        // R2 busy mode set / refresh
        cmd(K_MODE, 0, 0, 3'd3, 4'd2, "R2 mode set with open bank");
        nop(1);
        cmd(K_REF,  0, 0, 3'd0, 4'd3, "R2 refresh with open bank");
        // R5 / R6
        cmd(K_ACT,  1, 0, 3'd0, 4'd0, "R6 activate b1");
        cmd(K_PRE,  1, 0, 3'd0, 4'd7, "R5 precharge before tRAS");
        cmd(K_ACT,  1, 0, 3'd0, 4'd9, "R6 activate before tRP (R10 priority)");
        nop(2);
        cmd(K_ACT,  1, 0, 3'd0, 4'd8, "R6 activate open bank");
        cmd(K_ACT,  2, 0, 3'd0, 4'd11, "R6 activate before tRRD");
        // R7 all-bank and single-bank precharge
        cmd(K_PRE,  0, 1, 3'd0, 4'd7, "R7 all-bank precharge hits young bank");
        cmd(K_RD,   0, 0, 3'd0, 4'd5, "R7 b0 closed by all-bank precharge");
        nop(2);
        cmd(K_ACT,  0, 0, 3'd0, 4'd0, "R6 activate at tRP");
        nop(2);
        cmd(K_ACT,  3, 0, 3'd0, 4'd0, "R6 activate at tRRD");
        nop(8);
        cmd(K_PRE,  3, 0, 3'd0, 4'd0, "R5 precharge at tRAS");
        cmd(K_RD,   0, 0, 3'd0, 4'd0, "R7 b0 still open");
        cmd(K_RD,   3, 0, 3'd0, 4'd5, "R7 b3 closed");
        // R8 auto precharge, burst of 8
        cmd(K_ACT,  1, 0, 3'd0, 4'd0, "R8 activate b1");
        nop(3);
        cmd(K_RD,   0, 1, 3'd0, 4'd0, "R8 read with auto precharge");
        cmd(K_RD,   1, 0, 3'd0, 4'd4, "R8 read during lock first cycle");
        nop(5);
        cmd(K_WR,   1, 0, 3'd0, 4'd4, "R8 write during lock last cycle");
        cmd(K_RD,   1, 0, 3'd0, 4'd0, "R8 read other bank at burst end");
        nop(3);
        cmd(K_ACT,  0, 0, 3'd0, 4'd0, "R8 reactivate at burst end plus tRP");
        nop(8);
        cmd(K_PRE,  0, 1, 3'd0, 4'd0, "R7 close all");
        // R8 burst of 2
        cmd(K_MODE, 0, 0, 3'd1, 4'd0, "R8 mode set burst 2");
        nop(1);
        cmd(K_ACT,  2, 0, 3'd0, 4'd0, "R8 activate b2");
        nop(3);
        cmd(K_WR,   2, 1, 3'd0, 4'd0, "R8 write with auto precharge");
        cmd(K_RD,   2, 0, 3'd0, 4'd4, "R8 read inside 2-beat lock");
        nop(3);
        cmd(K_ACT,  2, 0, 3'd0, 4'd9, "R8 reactivate before tRP");
        // R1 ignored pins
        issue(K_MODE, 1'b0, 1'b0, 0, 0, 3'd0, 1'b1, 1'b0, 4'd0, "R1 cke low ignored");
        issue(K_ACT,  1'b1, 1'b1, 2, 0, 3'd0, 1'b1, 1'b0, 4'd0, "R1 cs high ignored");
        cmd(K_NOP,  0, 0, 3'd0, 4'd0, "R1 explicit nop");
        // R10 sticky hold and clear
        issue(K_REF,  1'b0, 1'b1, 0, 0, 3'd0, 1'b0, 1'b1, 4'd3, "R10 first violation held");
        issue(K_MODE, 1'b0, 1'b1, 0, 0, 3'd3, 1'b0, 1'b1, 4'd3, "R10 second violation keeps code");
        issue(K_NOP,  1'b0, 1'b1, 0, 0, 3'd0, 1'b0, 1'b0, 4'd3, "R10 pulse drops, code held");
        issue(K_NOP,  1'b0, 1'b1, 0, 0, 3'd0, 1'b1, 1'b0, 4'd0, "R10 clear");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule